// File: doc/BRIEF.md
# Element-Width Overlaid Register File

This block holds a set of 64-bit general-purpose registers and lets the same storage be used as one flat array of vector elements. That array is byte-addressable and little-endian. An access names a starting register, an element index and an element width of 8, 16, 32 or 64 bits. The block works out which register and which byte lane the element occupies. Element numbering runs on from one register into the next, so elements of any width pack densely across the whole file.

A write touches only the bytes the element covers. Data stored at one width can therefore be read back at any other width. For example, two adjacent 16-bit elements read together as one 32-bit element, with the higher-indexed element in the upper half. The byte ordering is fixed and no endianness mode affects it. There is one write port and one read port. Reads are registered and return the element zero-extended to 64 bits.

Top module: `ewrf_top`

## Requirements
- R1: An element's byte address is base×8 + index×(element bytes). The element lives in register (byte address / 8), starting at byte lane (byte address mod 8), with lane 0 in bits 7:0. Four 16-bit elements from one base fill bits 15:0, 31:16, 47:32 and 63:48 in index order.
- R2: Element numbering carries into the following registers. The 16-bit element at index 4 of base b sits in bits 15:0 of register b+1.
- R3: A write changes only the bytes its element covers. Every other byte of the target register and of all other registers keeps its value.
- R4: After 16-bit writes, the 32-bit element j reads as {element16[2j+1], element16[2j]}.
- R5: The width code is 2'b00 = 64, 2'b01 = 32, 2'b10 = 16 and 2'b11 = 8 bits. Write data bits above the element width are ignored.
- R6: A read accepted with rd_en returns its result on the next cycle, with rd_valid high for that one cycle. rd_data is zero-extended above the element width. rd_valid is low in any cycle after a cycle without rd_en.
- R7: When the byte address is at or beyond NUM_REGS×8, the access is out of range. For a write, wr_err is high on the next cycle and no byte changes. For a read, rd_err is high and rd_data is zero. wr_err is low after any cycle without wr_en.
- R8: When a read and a write hit the same bytes in one cycle, the read returns the value from before the write.
- R9: Reset clears every register to zero and drives rd_data, rd_valid, rd_err and wr_err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_base | input | RA_W (5) | Write base register |
| wr_idx | input | IDX_W (8) | Write element index |
| wr_width | input | 2 | Write element width code |
| wr_data | input | 64 | Write data, element in low bits |
| wr_err | output | 1 | Previous write was out of range |
| rd_en | input | 1 | Read request |
| rd_base | input | RA_W (5) | Read base register |
| rd_idx | input | IDX_W (8) | Read element index |
| rd_width | input | 2 | Read element width code |
| rd_data | output | 64 | Read element, zero-extended |
| rd_valid | output | 1 | rd_data holds a new result |
| rd_err | output | 1 | Previous read was out of range |

## Verification
The bench uses the default build of 32 registers with an 8-bit element index. That gives a byte space of 256. A single byte-wise fill therefore reaches every byte, and the sweeps can then read back every element at all four widths from base 0. Because the index is as wide as the byte space, base and index pairs can run past the last register. This reaches the out-of-range boundary at every width, including the very last valid byte and the first byte beyond it.

// File: rtl/ewrf_pkg.sv
package ewrf_pkg;
  typedef enum logic [1:0] {
    EW_64 = 2'b00,
    EW_32 = 2'b01,
    EW_16 = 2'b10,
    EW_8  = 2'b11
  } ew_t;

  localparam int unsigned WORD_W  = 64;
  localparam int unsigned WORD_B  = WORD_W / 8;

  // log2 of element size in bytes
  function automatic logic [1:0] ew_log2(input logic [1:0] w);
    return 2'd3 - w;
  endfunction

  // byte-enable pattern of an element placed at lane 0
  function automatic logic [7:0] ew_mask(input logic [1:0] w);
    case (w)
      EW_64:   return 8'hFF;
      EW_32:   return 8'h0F;
      EW_16:   return 8'h03;
      default: return 8'h01;
    endcase
  endfunction
endpackage

// File: rtl/ewrf_addr_map.sv
module ewrf_addr_map
  import ewrf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = 8,
  localparam int RA_W    = $clog2(NUM_REGS),
  localparam int BA_W    = RA_W + IDX_W + 4
) (
  input  logic [RA_W-1:0]  base,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       width,
  output logic [RA_W-1:0]  reg_sel,
  output logic [2:0]       lane,
  output logic [7:0]       be,
  output logic             err
);
  localparam logic [BA_W-1:0] TOTAL_B = BA_W'(NUM_REGS * 8);

  logic [BA_W-1:0] base_b;
  logic [BA_W-1:0] off_b;
  logic [BA_W-1:0] byte_addr;

  always_comb begin
    base_b    = BA_W'(base) << 3;
    off_b     = BA_W'(idx) << ew_log2(width);
    byte_addr = base_b + off_b;
    err       = (byte_addr >= TOTAL_B);
    reg_sel   = byte_addr[RA_W+2:3];
    lane      = byte_addr[2:0];
    be        = err ? 8'h00 : 8'(ew_mask(width) << lane);
  end
endmodule

// File: rtl/ewrf_lane_align.sv
module ewrf_lane_align
  import ewrf_pkg::*;
(
  input  logic [2:0]        wr_lane,
  input  logic [WORD_W-1:0] wr_elem,
  output logic [WORD_W-1:0] wr_word,
  input  logic [2:0]        rd_lane,
  input  logic [1:0]        rd_width,
  input  logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_elem
);
  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] keep;

  always_comb begin
    // byte enables select the valid lanes, so only the shift is needed
    wr_word = wr_elem << {wr_lane, 3'b000};
    shifted = rd_word >> {rd_lane, 3'b000};
    for (int b = 0; b < WORD_B; b++)
      keep[b*8 +: 8] = {8{ew_mask(rd_width)[b]}};
    rd_elem = shifted & keep;
  end
endmodule

// File: rtl/ewrf_storage.sv
module ewrf_storage
  import ewrf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int RA_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RA_W-1:0]   waddr,
  input  logic [7:0]        wbe,
  input  logic [WORD_W-1:0] wword,
  input  logic [RA_W-1:0]   raddr,
  output logic [WORD_W-1:0] rword
);
  logic [WORD_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) mem[r] <= '0;
    end else begin
      for (int b = 0; b < WORD_B; b++)
        if (wbe[b]) mem[waddr][b*8 +: 8] <= wword[b*8 +: 8];
    end
  end

  // old contents are seen by a read in the same cycle as a write
  assign rword = mem[raddr];
endmodule

// File: rtl/ewrf_top.sv
module ewrf_top
  import ewrf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = 8,
  localparam int RA_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   wr_base,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_width,
  input  logic [63:0]       wr_data,
  output logic              wr_err,
  input  logic              rd_en,
  input  logic [RA_W-1:0]   rd_base,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [1:0]        rd_width,
  output logic [63:0]       rd_data,
  output logic              rd_valid,
  output logic              rd_err
);
  logic [RA_W-1:0]   w_reg, r_reg;
  logic [2:0]        w_lane, r_lane;
  logic [7:0]        w_be_raw, r_be_unused;
  logic              w_oob, r_oob;
  logic [WORD_W-1:0] w_word, r_word, r_elem;
  logic [7:0]        w_be;

  ewrf_addr_map #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) wmap_i (
    .base(wr_base), .idx(wr_idx), .width(wr_width),
    .reg_sel(w_reg), .lane(w_lane), .be(w_be_raw), .err(w_oob)
  );

  ewrf_addr_map #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) rmap_i (
    .base(rd_base), .idx(rd_idx), .width(rd_width),
    .reg_sel(r_reg), .lane(r_lane), .be(r_be_unused), .err(r_oob)
  );

  ewrf_lane_align align_i (
    .wr_lane(w_lane), .wr_elem(wr_data), .wr_word(w_word),
    .rd_lane(r_lane), .rd_width(rd_width), .rd_word(r_word),
    .rd_elem(r_elem)
  );

  assign w_be = wr_en ? w_be_raw : 8'h00;

  ewrf_storage #(.NUM_REGS(NUM_REGS)) store_i (
    .clk(clk), .rst(rst),
    .waddr(w_reg), .wbe(w_be), .wword(w_word),
    .raddr(r_reg), .rword(r_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      wr_err   <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      wr_err   <= wr_en & w_oob;
      if (rd_en) begin
        rd_data <= r_oob ? '0 : r_elem;
        rd_err  <= r_oob;
      end
    end
  end
endmodule

// File: rtl/ewrf_checker.sv
module ewrf_checker #(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = 8,
  localparam int RA_W    = $clog2(NUM_REGS)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [RA_W-1:0]  wr_base,
  input logic [IDX_W-1:0] wr_idx,
  input logic [1:0]       wr_width,
  input logic             wr_err,
  input logic             rd_en,
  input logic [1:0]       rd_width,
  input logic [63:0]      rd_data,
  input logic             rd_valid,
  input logic             rd_err
);
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  a_r6_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  a_r6_zext_8: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_width == 2'b11 |=> rd_data[63:8] == '0);
  a_r6_zext_16: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_width == 2'b10 |=> rd_data[63:16] == '0);
  a_r6_zext_32: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_width == 2'b01 |=> rd_data[63:32] == '0);
  a_r7_err_zero_data: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> rd_data == '0);
  a_r7_no_err_idle: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !wr_err);
  a_r7_past_last: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_base == RA_W'(NUM_REGS - 1) && wr_width == 2'b00 && wr_idx == IDX_W'(1)
    |=> wr_err);
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !rd_valid && !rd_err && !wr_err));
endmodule

bind ewrf_top ewrf_checker #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/ewrf_top_tb_top.sv
module ewrf_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int NBYTE = NREG * 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  wr_base = '0, rd_base = '0;
  logic [7:0]  wr_idx = '0, rd_idx = '0;
  logic [1:0]  wr_width = '0, rd_width = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        wr_err, rd_valid, rd_err;

  int total = 0;
  int bad = 0;
  logic [7:0] mdl [NBYTE];
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  ewrf_top dut_i (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] w);
    return 8 >> w;
  endfunction

  function automatic logic [63:0] model_rd(input int ba, input int nb);
    logic [63:0] v = '0;
    if (ba >= NBYTE) return '0;
    for (int k = 0; k < nb; k++) v[k*8 +: 8] = mdl[ba + k];
    return v;
  endfunction

  task automatic wr(input int base, input int idx, input logic [1:0] w,
                    input logic [63:0] d, input string tag);
    int nb = nbytes(w);
    int ba = base * 8 + idx * nb;
    @(negedge clk);
    wr_en = 1'b1; wr_base = 5'(base); wr_idx = 8'(idx); wr_width = w; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk({tag, " wr_err"}, 64'(wr_err), 64'(ba >= NBYTE));
    if (ba < NBYTE)
      for (int k = 0; k < nb; k++) mdl[ba + k] = d[k*8 +: 8];
  endtask

  task automatic rd_exp(input int base, input int idx, input logic [1:0] w,
                        input logic [63:0] exp, input string tag);
    int ba = base * 8 + idx * nbytes(w);
    @(negedge clk);
    rd_en = 1'b1; rd_base = 5'(base); rd_idx = 8'(idx); rd_width = w;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    chk({tag, " data"}, rd_data, exp);
    chk({tag, " rd_err"}, 64'(rd_err), 64'(ba >= NBYTE));
    chk({tag, " R6 valid"}, 64'(rd_valid), 64'd1);
  endtask

  task automatic rd(input int base, input int idx, input logic [1:0] w, input string tag);
    rd_exp(base, idx, w, model_rd(base * 8 + idx * nbytes(w), nbytes(w)), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NBYTE; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R9: outputs and storage cleared
    chk("R9 rd_valid", 64'(rd_valid), 0);
    chk("R9 wr_err", 64'(wr_err), 0);
    chk("R9 rd_data", rd_data, 0);
    for (int r = 0; r < NREG; r++) rd_exp(r, 0, 2'b00, 64'd0, "R9 reg zero");

    // R5: byte-wise fill of the whole space with width code 11, junk upper data
    for (int i = 0; i < NBYTE; i++)
      wr(0, i, 2'b11, {56'hDEAD_BEEF_CAFE_01, 8'(i * 37 + 5)}, "R5 fill8");
    // R1/R5/R6: read every element at every width from base 0
    for (int w = 0; w < 4; w++)
      for (int i = 0; i < NBYTE / nbytes(2'(w)); i++) rd(0, i, 2'(w), "R1 sweep");
    // idle cycle: valid drops
    @(negedge clk);
    chk("R6 idle valid", 64'(rd_valid), 0);

    // R1/R2/R4: explicit 16-bit packing
    for (int k = 0; k < 5; k++) wr(2, k, 2'b10, 64'hFFFF_0000_0000_A000 + 64'(k), "R1 wr16");
    rd_exp(2, 0, 2'b00, 64'hA003_A002_A001_A000, "R1 pack16");
    rd_exp(3, 0, 2'b10, 64'h0000_0000_0000_A004, "R2 carry16");
    rd_exp(2, 4, 2'b10, 64'h0000_0000_0000_A004, "R2 idx4");
    rd_exp(2, 0, 2'b01, 64'h0000_0000_A001_A000, "R4 view32 j0");
    rd_exp(2, 1, 2'b01, 64'h0000_0000_A003_A002, "R4 view32 j1");
    rd(3, 0, 2'b00, "R3 reg3 upper kept");

    // R3: single byte write, neighbours intact
    wr(10, 3, 2'b11, 64'h5A, "R3 wr8");
    rd(9, 0, 2'b00, "R3 reg9");
    rd(10, 0, 2'b00, "R3 reg10");
    rd(11, 0, 2'b00, "R3 reg11");
    rd_exp(10, 3, 2'b11, 64'h5A, "R3 byte");

    // R3/R5: mixed pseudo-random traffic with model readback
    for (int n = 0; n < 400; n++) begin
      logic [1:0] w;
      int b, ix, mx;
      seed = seed * 32'd1664525 + 32'd1013904223;
      w = seed[31:30];
      b = int'(seed[29:25]);
      mx = (NBYTE / nbytes(w));
      ix = int'(seed[23:16]) % mx;
      wr(b, ix, w, {seed, ~seed}, "R3 mix wr");
      seed = seed * 32'd1664525 + 32'd1013904223;
      rd(int'(seed[29:25]), int'(seed[23:16]) % (NBYTE / nbytes(seed[31:30])),
         seed[31:30], "R3 mix rd");
    end
    for (int r = 0; r < NREG; r++) rd(r, 0, 2'b00, "R3 final");

    // R7: out-of-range boundaries
    rd(31, 0, 2'b00, "R7 pre");
    wr(31, 1, 2'b00, 64'h1111_2222_3333_4444, "R7 wr64 oob");
    wr(0, 256 / 2, 2'b10, 64'h7777, "R7 wr16 oob");
    wr(31, 8, 2'b11, 64'h99, "R7 wr8 oob");
    rd(31, 0, 2'b00, "R7 unchanged");
    rd_exp(31, 8, 2'b11, 64'd0, "R7 rd oob");
    rd_exp(16, 16, 2'b00, 64'd0, "R7 rd64 oob");
    wr(0, 255, 2'b11, 64'hC3, "R7 last byte");
    rd_exp(31, 7, 2'b11, 64'hC3, "R7 last byte rd");
    @(negedge clk);
    chk("R7 wr_err idle", 64'(wr_err), 0);

    // R8: read and write same bytes in one cycle return old data
    @(negedge clk);
    wr_en = 1'b1; wr_base = 5'd6; wr_idx = 8'd1; wr_width = 2'b01; wr_data = 64'h0BAD_F00D;
    rd_en = 1'b1; rd_base = 5'd6; rd_idx = 8'd1; rd_width = 2'b01;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R8 old value", rd_data, model_rd(52, 4));
    for (int k = 0; k < 4; k++) mdl[52 + k] = wr_data[k*8 +: 8];
    rd_exp(6, 1, 2'b01, 64'h0BAD_F00D, "R8 new value");

    // R9: reset again clears storage
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R9 rd_data again", rd_data, 0);
    rd_exp(6, 0, 2'b00, 64'd0, "R9 cleared");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule